// File: doc/BRIEF.md
# 8-bit Timer/Counter with Two Compare Channels

This block is an 8-bit counter that advances on a timer clock enable. The enable comes from a free-running prescaler (system clock divided by 1, 8, 64, 256 or 1024) or from an external input pin. The pin is synchronized and edge-detected on a selectable edge. Software sets it up through a small register bus. The bus has a write strobe, a 3-bit address, write data, and read data that is returned in the same cycle.

The counter runs in one of four modes:
- Free-running wrap.
- Clear when the count matches compare A.
- Up/down with the turning point fixed at the maximum count.
- Up/down with the turning point taken from compare A.

Two compare channels each hold a software-visible buffer and an active value. The active value is used for matching and is loaded from the buffer at a mode-dependent point. A match sets that channel's flag and can toggle a waveform output. Overflow or bottom events set a third flag. Each flag drives its interrupt line only when its mask bit is set.

Top module: `tmr8_top`

## Requirements
- R1: After reset the count, control, mask and flag registers read 0, and `irq`, `outA` and `outB` are 0.
- R2: With clock select 0 the count holds its value indefinitely.
- R3: Clock select values 1, 2, 3, 4 and 5 advance the count by one every 1, 8, 64, 256 and 1024 system clocks. Over any run of N×k consecutive clocks at divide-by-k the count advances exactly N.
- R4: Clock select 7 counts rising edges of `extPin` and select 6 counts falling edges. The count changes on the third rising system clock edge after the pin changes. Opposite edges are not counted.
- R5: In mode 0, a tick at count 0xFF wraps the count to 0x00 and sets flag bit 0 (overflow).
- R6: In mode 1, a tick while the count equals active compare A loads 0 into the count, and the compare A flag (bit 1) is set.
- R7: In modes 2 and 3 the counter counts up to the turning point (0xFF in mode 2, active compare A in mode 3), then down to 0, then up again. A tick at count 0 sets flag bit 0.
- R8: Reading a compare address returns its buffer. In mode 0 a write reaches the active value at once. In mode 1 the active value loads from the buffer on the tick at the turning point, and in modes 2 and 3 on the tick at count 0.
- R9: A tick while the count equals a channel's active value sets that channel's flag: bit 1 for A, bit 2 for B.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it. A hardware set in the same cycle as a clear leaves the flag set.
- R11: `irq[i]` is 1 exactly when flag bit i and mask bit i are both 1.
- R12: A compare match toggles `outA` (or `outB`) only when control bit 5 (or bit 6) is set. Otherwise the output holds.
- R13: A bus write to the count takes effect even on a cycle that carries a tick.
- R14: The register map is: 0 control {bit6 toggle-B, bit5 toggle-A, bits4:3 mode, bits2:0 clock select}, 1 count, 2 compare A, 3 compare B, 4 flags, 5 mask. Unused bits and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data, combinational from `busAddr` |
| extPin | input | 1 | External count input, asynchronous |
| outA | output | 1 | Channel A waveform output |
| outB | output | 1 | Channel B waveform output |
| irq | output | 3 | Masked requests: bit0 overflow, bit1 compare A, bit2 compare B |

## Verification
The delicate coincidence is a hardware flag set landing on the same edge as a software write-one-to-clear of that flag. The bench provokes it by parking the count at 0xFF and then issuing back-to-back bus writes. The first write starts the divide-by-1 clock, and the second writes 1 to the overflow bit on exactly the edge where the wrap occurs. The flag must still read 1 afterwards, and a later clear with no event must take it to 0. The same back-to-back technique is used to collide a count write with a tick.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int NUM_CH   = 2;
  localparam int NUM_FLAG = 3;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd5;

  typedef enum logic [2:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV64   = 3'd3,
    CS_DIV256  = 3'd4,
    CS_DIV1024 = 3'd5,
    CS_EXTFALL = 3'd6,
    CS_EXTRISE = 3'd7
  } clkSel_e;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_CLRMATCH = 2'd1,
    MODE_UPDN_FIX = 2'd2,
    MODE_UPDN_CMP = 2'd3
  } mode_e;

  typedef struct packed {
    logic    togB;
    logic    togA;
    mode_e   mode;
    clkSel_e clkSel;
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);

  // control -> datapath strobes
  typedef struct packed {
    logic              tick;
    logic              cntWr;
    logic [NUM_CH-1:0] cmpWr;
    logic [NUM_CH-1:0] togEn;
    mode_e             mode;
  } ctlStrobe_t;

  // datapath -> control events, bit order equals flag order
  typedef struct packed {
    logic matchB;
    logic matchA;
    logic ovf;
  } tmrEvent_t;

endpackage

// File: rtl/tmr8_clksel.sv
module tmr8_clksel
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] clkSel,
  input  logic       extPin,
  output logic       tick
);

  localparam int NUM_DIV = 4;
  localparam int DivShift [NUM_DIV] = '{3, 6, 8, 10};

  logic [PRE_W-1:0]   preQ;
  logic [2:0]         syncQ;
  logic [NUM_DIV-1:0] divTick;
  logic               extRise;
  logic               extFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ  <= '0;
      syncQ <= '0;
    end else begin
      preQ  <= preQ + 1'b1;
      syncQ <= {syncQ[1:0], extPin};
    end
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : gDiv
    localparam logic [PRE_W-1:0] TapMask = PRE_W'((1 << DivShift[g]) - 1);
    assign divTick[g] = ((preQ & TapMask) == TapMask);
  end

  assign extRise = syncQ[1] & ~syncQ[2];
  assign extFall = ~syncQ[1] & syncQ[2];

  always_comb begin
    case (clkSel_e'(clkSel))
      CS_DIV1:    tick = 1'b1;
      CS_DIV8:    tick = divTick[0];
      CS_DIV64:   tick = divTick[1];
      CS_DIV256:  tick = divTick[2];
      CS_DIV1024: tick = divTick[3];
      CS_EXTFALL: tick = extFall;
      CS_EXTRISE: tick = extRise;
      default:    tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr8_ctrl.sv
module tmr8_ctrl
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CNT_W-1:0]    busWdata,
  output logic [CNT_W-1:0]    busRdata,
  input  logic                tick,
  input  tmrEvent_t           evt,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [CNT_W-1:0]    bufA,
  input  logic [CNT_W-1:0]    bufB,
  output logic [2:0]          clkSel,
  output ctlStrobe_t          stb,
  output logic [NUM_FLAG-1:0] flags,
  output logic [NUM_FLAG-1:0] irq
);

  ctrlReg_t            ctrlQ;
  logic [NUM_FLAG-1:0] maskQ;
  logic [NUM_FLAG-1:0] flagQ;
  logic [NUM_FLAG-1:0] flagClr;
  logic [NUM_FLAG-1:0] flagSet;

  assign flagClr = (busWe && busAddr == ADDR_FLAG) ? busWdata[NUM_FLAG-1:0] : '0;
  assign flagSet = evt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      maskQ <= '0;
      flagQ <= '0;
    end else begin
      if (busWe && busAddr == ADDR_CTRL) ctrlQ <= ctrlReg_t'(busWdata[CTRL_W-1:0]);
      if (busWe && busAddr == ADDR_MASK) maskQ <= busWdata[NUM_FLAG-1:0];
      flagQ <= (flagQ & ~flagClr) | flagSet;
    end
  end

  assign clkSel    = ctrlQ.clkSel;
  assign stb.tick  = tick;
  assign stb.cntWr = busWe && busAddr == ADDR_CNT;
  assign stb.cmpWr = {busWe && busAddr == ADDR_CMPB, busWe && busAddr == ADDR_CMPA};
  assign stb.togEn = {ctrlQ.togB, ctrlQ.togA};
  assign stb.mode  = ctrlQ.mode;
  assign flags     = flagQ;
  assign irq       = flagQ & maskQ;

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = CNT_W'(ctrlQ);
      ADDR_CNT:  busRdata = cnt;
      ADDR_CMPA: busRdata = bufA;
      ADDR_CMPB: busRdata = bufB;
      ADDR_FLAG: busRdata = CNT_W'(flagQ);
      ADDR_MASK: busRdata = CNT_W'(maskQ);
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr8_cmpch.sv
module tmr8_cmpch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             immediate,
  input  logic             load,
  input  logic             tick,
  input  logic             togEn,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] bufVal,
  output logic [CNT_W-1:0] actVal,
  output logic             match,
  output logic             wave
);

  logic [CNT_W-1:0] bufQ;
  logic [CNT_W-1:0] actQ;
  logic             waveQ;

  assign match = tick && (cnt == actQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ  <= '0;
      actQ  <= '0;
      waveQ <= 1'b0;
    end else begin
      if (wr) bufQ <= wdata;
      if (immediate && wr) actQ <= wdata;
      else if (load)       actQ <= bufQ;
      if (match && togEn) waveQ <= ~waveQ;
    end
  end

  assign bufVal = bufQ;
  assign actVal = actQ;
  assign wave   = waveQ;

endmodule

// File: rtl/tmr8_dpath.sv
module tmr8_dpath
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       stb,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] actA,
  output logic [CNT_W-1:0] bufA,
  output logic [CNT_W-1:0] bufB,
  output tmrEvent_t        evt,
  output logic             outA,
  output logic             outB
);

  localparam logic [CNT_W-1:0] MaxVal = '1;

  logic [CNT_W-1:0]              cntQ, cntNext;
  logic                          dirUpQ, dirNext;
  logic [CNT_W-1:0]              topVal;
  logic                          atTop, atBottom, upDown;
  logic                          loadNow, immediate;
  logic [NUM_CH-1:0][CNT_W-1:0]  bufVal, actVal;
  logic [NUM_CH-1:0]             match, wave;

  assign upDown    = stb.mode[1];
  assign topVal    = (stb.mode == MODE_FREE || stb.mode == MODE_UPDN_FIX) ? MaxVal : actVal[0];
  assign atTop     = (cntQ == topVal);
  assign atBottom  = (cntQ == '0);
  assign immediate = (stb.mode == MODE_FREE);

  always_comb begin
    case (stb.mode)
      MODE_FREE:     loadNow = 1'b1;
      MODE_CLRMATCH: loadNow = stb.tick && atTop;
      default:       loadNow = stb.tick && atBottom;
    endcase
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    tmr8_cmpch #(.CNT_W(CNT_W)) uCh (
      .clk       (clk),
      .rstN      (rstN),
      .wr        (stb.cmpWr[ch]),
      .wdata     (wdata),
      .immediate (immediate),
      .load      (loadNow),
      .tick      (stb.tick),
      .togEn     (stb.togEn[ch]),
      .cnt       (cntQ),
      .bufVal    (bufVal[ch]),
      .actVal    (actVal[ch]),
      .match     (match[ch]),
      .wave      (wave[ch])
    );
  end

  always_comb begin
    cntNext = cntQ;
    dirNext = dirUpQ;
    if (stb.cntWr) begin
      cntNext = wdata;
    end else if (stb.tick) begin
      case (stb.mode)
        MODE_FREE:     cntNext = cntQ + 1'b1;
        MODE_CLRMATCH: cntNext = atTop ? '0 : cntQ + 1'b1;
        default: begin
          if (atBottom) begin
            dirNext = 1'b1;
            cntNext = (topVal == '0) ? '0 : cntQ + 1'b1;
          end else if (atTop) begin
            dirNext = 1'b0;
            cntNext = cntQ - 1'b1;
          end else begin
            cntNext = dirUpQ ? cntQ + 1'b1 : cntQ - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      dirUpQ <= 1'b1;
    end else begin
      cntQ   <= cntNext;
      dirUpQ <= dirNext;
    end
  end

  assign evt.ovf    = stb.tick && (upDown ? atBottom : (cntQ == MaxVal));
  assign evt.matchA = match[0];
  assign evt.matchB = match[1];

  assign cnt  = cntQ;
  assign actA = actVal[0];
  assign bufA = bufVal[0];
  assign bufB = bufVal[1];
  assign outA = wave[0];
  assign outB = wave[1];

endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [2:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic             extPin,
  output logic             outA,
  output logic             outB,
  output logic [2:0]       irq
);

  logic [2:0]          clkSel;
  logic                tick;
  ctlStrobe_t          stb;
  tmrEvent_t           evt;
  logic [CNT_W-1:0]    cnt, actA, bufA, bufB;
  logic [NUM_FLAG-1:0] flags;

  tmr8_clksel #(.PRE_W(PRE_W)) uClk (
    .clk    (clk),
    .rstN   (rstN),
    .clkSel (clkSel),
    .extPin (extPin),
    .tick   (tick)
  );

  tmr8_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .tick     (tick),
    .evt      (evt),
    .cnt      (cnt),
    .bufA     (bufA),
    .bufB     (bufB),
    .clkSel   (clkSel),
    .stb      (stb),
    .flags    (flags),
    .irq      (irq)
  );

  tmr8_dpath #(.CNT_W(CNT_W)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (busWdata),
    .cnt   (cnt),
    .actA  (actA),
    .bufA  (bufA),
    .bufB  (bufB),
    .evt   (evt),
    .outA  (outA),
    .outB  (outB)
  );

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          clkSel,
  input ctlStrobe_t          stb,
  input tmrEvent_t           evt,
  input logic [CNT_W-1:0]    cnt,
  input logic [CNT_W-1:0]    actA,
  input logic [NUM_FLAG-1:0] flags,
  input logic                outA
);

  localparam logic [CNT_W-1:0] MaxVal = '1;

  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0 && !stb.cntWr) |=> $stable(cnt));

  a_r3_div1_step: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd1 && stb.mode == MODE_FREE && !stb.cntWr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r5_wrap_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode == MODE_FREE && stb.tick && cnt == MaxVal && !stb.cntWr) |=> (cnt == '0 && flags[0]));

  a_r6_clear_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode == MODE_CLRMATCH && stb.tick && cnt == actA && !stb.cntWr) |=> (cnt == '0 && flags[1]));

  a_r7_bottom_turn: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode[1] && stb.tick && cnt == '0 && !stb.cntWr && (stb.mode == MODE_UPDN_FIX || actA != '0))
      |=> cnt == CNT_W'(1));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovf |=> flags[0]);

  a_r12_toggle_a: assert property (@(posedge clk) disable iff (!rstN)
    (evt.matchA && stb.togEn[0]) |=> outA != $past(outA));

endmodule

bind tmr8_top tmr8_chk #(.CNT_W(CNT_W)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .clkSel (clkSel),
  .stb    (stb),
  .evt    (evt),
  .cnt    (cnt),
  .actA   (actA),
  .flags  (flags),
  .outA   (outA)
);

// File: tb/tb_tmr8_top.sv
`timescale 1ns/1ps
module tb_tmr8_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       extPin = 1'b0;
  logic       outA, outB;
  logic [2:0] irq;

  int nChk = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  tmr8_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .extPin   (extPin),
    .outA     (outA),
    .outB     (outB),
    .irq      (irq)
  );

  typedef struct packed {
    logic [2:0] a;
    logic [7:0] d;
    logic [7:0] e;
  } vec_t;

  // R14 register map readback vectors: write d to a, read back e
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'hE0, 8'h60},
    '{3'd0, 8'h00, 8'h00},
    '{3'd1, 8'h5A, 8'h5A},
    '{3'd2, 8'hC3, 8'hC3},
    '{3'd3, 8'h3C, 8'h3C},
    '{3'd5, 8'hFF, 8'h07},
    '{3'd5, 8'h00, 8'h00},
    '{3'd6, 8'h12, 8'h00},
    '{3'd7, 8'h34, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // checks now, then advances one clock
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
    @(negedge clk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    cyc(4);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 outA", outA, 0);
    check("R1 outB", outB, 0);
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h00, "R1 count");
    rd(3'd4, 8'h00, "R1 flags");
    rd(3'd5, 8'h00, "R1 mask");

    // R14 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, VECS[i].e, $sformatf("R14 vec%0d", i));
    end

    // R2 stopped holds
    wr(3'd1, 8'h10);
    cyc(20);
    rd(3'd1, 8'h10, "R2 hold");

    // R3 prescaler rates: run k edges then stop edge = k+1 ticks windows
    wr(3'd1, 8'h00); wr(3'd0, 8'h01); cyc(4);    wr(3'd0, 8'h00);
    rd(3'd1, 8'd5, "R3 div1");
    wr(3'd1, 8'h00); wr(3'd0, 8'h02); cyc(63);   wr(3'd0, 8'h00);
    rd(3'd1, 8'd8, "R3 div8");
    wr(3'd1, 8'h00); wr(3'd0, 8'h03); cyc(255);  wr(3'd0, 8'h00);
    rd(3'd1, 8'd4, "R3 div64");
    wr(3'd1, 8'h00); wr(3'd0, 8'h04); cyc(1023); wr(3'd0, 8'h00);
    rd(3'd1, 8'd4, "R3 div256");
    wr(3'd1, 8'h00); wr(3'd0, 8'h05); cyc(2047); wr(3'd0, 8'h00);
    rd(3'd1, 8'd2, "R3 div1024");

    // R4 external edges
    wr(3'd1, 8'h00); wr(3'd0, 8'h07);
    extPin = 1'b1; cyc(2);
    rd(3'd1, 8'd0, "R4 latency before third edge");
    rd(3'd1, 8'd1, "R4 rising counted");
    extPin = 1'b0; cyc(5);
    rd(3'd1, 8'd1, "R4 falling ignored in rising select");
    wr(3'd0, 8'h06);
    extPin = 1'b1; cyc(5);
    rd(3'd1, 8'd1, "R4 rising ignored in falling select");
    extPin = 1'b0; cyc(5);
    rd(3'd1, 8'd2, "R4 falling counted");
    wr(3'd0, 8'h00);

    // R5 wrap with R11 masking
    wr(3'd4, 8'h07); wr(3'd5, 8'h01); wr(3'd1, 8'hFE);
    wr(3'd0, 8'h01); cyc(1); wr(3'd0, 8'h00);
    check("R11 irq ovf only", irq, 3'b001);
    rd(3'd1, 8'h00, "R5 wrap count");
    rd(3'd4, 8'h01, "R5 overflow flag");

    // R10 set beats clear on the same edge
    wr(3'd4, 8'h07);
    rd(3'd4, 8'h00, "R10 clear all");
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd4, 8'h01, "R10 set wins");
    wr(3'd4, 8'h01);
    rd(3'd4, 8'h00, "R10 plain clear");

    // R9 / R11 / R12 compare matches, toggle on A only
    wr(3'd5, 8'h00); wr(3'd2, 8'h05); wr(3'd3, 8'h02); wr(3'd1, 8'h00);
    wr(3'd0, 8'h21); cyc(6); wr(3'd0, 8'h00);
    check("R12 outA toggled", outA, 1);
    check("R12 outB held", outB, 0);
    check("R11 irq masked off", irq, 3'b000);
    rd(3'd4, 8'h06, "R9 both compare flags");
    rd(3'd1, 8'd7, "R9 count after run");
    wr(3'd5, 8'h06);
    check("R11 irq compare lines", irq, 3'b110);

    // R6 clear on match A
    wr(3'd4, 8'h07); wr(3'd5, 8'h00); wr(3'd2, 8'h03); wr(3'd1, 8'h00);
    wr(3'd0, 8'h09); cyc(3); wr(3'd0, 8'h08);
    rd(3'd1, 8'h00, "R6 cleared after match");
    rd(3'd4, 8'h06, "R6 compare flags");

    // R8 buffered load at turning point in mode 1
    wr(3'd2, 8'h06);
    rd(3'd2, 8'h06, "R8 buffer readback");
    wr(3'd0, 8'h09); cyc(9); wr(3'd0, 8'h08);
    rd(3'd1, 8'd6, "R8 new top after reload");

    // R7 up/down with top from compare A
    wr(3'd0, 8'h00); wr(3'd2, 8'h04); wr(3'd0, 8'h18); wr(3'd1, 8'h00);
    wr(3'd0, 8'h19); cyc(4); wr(3'd0, 8'h18);
    rd(3'd1, 8'd3, "R7 turned at compare A");
    wr(3'd0, 8'h19); cyc(2); wr(3'd0, 8'h18);
    rd(3'd1, 8'd0, "R7 reached bottom");
    wr(3'd4, 8'h07);
    wr(3'd0, 8'h19); wr(3'd0, 8'h18);
    rd(3'd1, 8'd1, "R7 turned at bottom");
    rd(3'd4, 8'h01, "R7 bottom sets overflow flag");

    // R7 up/down with fixed top
    wr(3'd0, 8'h10); wr(3'd1, 8'hFE);
    wr(3'd0, 8'h11); cyc(1); wr(3'd0, 8'h10);
    rd(3'd1, 8'hFE, "R7 turned at 0xFF");

    // R13 count write beats tick
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd0, 8'h01); cyc(3); wr(3'd1, 8'h40); wr(3'd0, 8'h00);
    rd(3'd1, 8'h41, "R13 write over tick");

    summary();
    $finish;
  end

endmodule